// File: doc/BRIEF.md
# Prioritized Slot Interrupt Aggregator

This block gathers level-sensitive interrupt requests from four expansion slots of sixteen lines each. Every line passes through a per-slot mask before it reaches the slot's status word. Each slot's status is folded into a one-bit pending summary. In accelerated mode, a single interrupt output is raised from these summaries. A read of the acknowledge word returns an 8-bit vector for the highest-priority unmasked request. That read is pure combinational decode with no side effects.

Software reaches the block through a small word-wide register port. The port holds a configuration word, a master word, an acknowledge word, four mask words and four read-only status words. The master word carries the slot summaries, a routing mode bit, a legacy enable bit, a mask-enable bit and a global summary mask. In mode 0 the block acts as a pass-through toward a legacy router: the output is just the legacy enable ANDed with any raw request. Only mode 1 uses the per-slot summaries to drive the output.

Top module: `slot_irq_aggregator`

Register map (addr_i):

| Address | Word |
|---|---|
| 0 | configuration |
| 1 | master |
| 2 | acknowledge, low 8 bits |
| 4+s | mask of slot s |
| 8+s | status of slot s |

Master bits:

| Bits | Field |
|---|---|
| [3:0] | summary, read-only, bit s for slot s |
| [4] | mode |
| [5] | legacy enable |
| [6] | mask enable |
| [11:8] | global mask |

Slot s, line b maps to req_i[s*16+b].

## Requirements
- R1: After reset every mask word reads 0xFFFF. The master word, the configuration word and irq_o read 0, and the acknowledge word reads 0x00FF.
- R2: The status word of slot s reads req_i[s*16 +: 16] AND NOT mask of slot s. A line whose mask bit is 1 never reads as set.
- R3: Master bit s reads 1 exactly when status word s is non-zero and slot s is not blocked by the global mask (see R10).
- R4: Among pending slots, slot 0 has the highest priority and slot 3 the lowest.
- R5: Within the chosen slot, the lowest-numbered set status bit wins.
- R6: The acknowledge value is the 8-bit sum ((slot+1)*16)+(line+1), with slot and line counted from zero. Examples: slot 1 line 3 gives 0x24, and slot 0 line 15 gives 0x20.
- R7: The acknowledge word reads 0xFF when no summary bit is set.
- R8: With mode 1, irq_o is 1 exactly when at least one summary bit is set.
- R9: With mode 0, irq_o equals legacy enable AND (any bit of req_i), whatever the masks.
- R10: When mask enable is 1, a set global mask bit s clears summary s and removes slot s from acknowledge selection. When mask enable is 0, the global mask has no effect.
- R11: Reading the acknowledge word changes no state. A status bit clears as soon as its request deasserts.
- R12: The configuration word reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low synchronous reset |
| wr_en_i | input | 1 | register write strobe |
| addr_i | input | 4 | register address |
| wdata_i | input | 16 | write data |
| rdata_o | output | 16 | combinational read data |
| req_i | input | 64 | level requests, slot-major |
| irq_o | output | 1 | combined interrupt |

## Verification
The hardest case to reach is a tie between priority layers. Several slots must be pending at once, each with several lines set, while the global mask and the mask enable change which slot is even eligible. The bench first opens masks on more than one slot. It then drives multi-bit request patterns in which the lowest slot and the lowest line disagree with the highest raw bit. It also toggles mask enable with a global mask bit left set, so that the acknowledge word must move between slots with no change in req_i. Line 15 is driven on its own to expose the carry of the nibble sum into the slot field.

// File: rtl/slot_irq_aggregator.sv
module slot_irq_aggregator #(
  parameter int SLOTS = 4,
  parameter int LINES = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [3:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  input  logic [SLOTS*LINES-1:0] req_i,
  output logic        irq_o
);
  localparam int REQW = SLOTS * LINES;
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int LW   = $clog2(LINES);

  logic [15:0]      cfg_q;
  logic             mode_q, len_q, msken_q;
  logic [SLOTS-1:0] gmask_q;
  logic [REQW-1:0]  mask_q;
  logic [REQW-1:0]  status;
  logic [SLOTS-1:0] pend, eff;
  logic [SW-1:0]    sel;
  logic [LW-1:0]    line;
  logic [LINES-1:0] sel_word;
  logic [7:0]       ack;

  assign status = req_i & ~mask_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_pend
    assign pend[s] = |status[s*LINES +: LINES];
  end

  assign eff = pend & ~(msken_q ? gmask_q : '0);

  always_comb begin
    sel = '0;
    for (int s = SLOTS - 1; s >= 0; s--)
      if (eff[s]) sel = SW'(s);
    sel_word = status[sel*LINES +: LINES];
    line = '0;
    for (int b = LINES - 1; b >= 0; b--)
      if (sel_word[b]) line = LW'(b);
    if (eff == '0 || sel_word == '0) ack = 8'hFF;
    else ack = 8'((32'(sel) + 1) * 16 + 32'(line) + 1);
  end

  assign irq_o = mode_q ? |eff : (len_q & |req_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      mode_q  <= 1'b0;
      len_q   <= 1'b0;
      msken_q <= 1'b0;
      gmask_q <= '0;
      mask_q  <= '1;
    end else if (wr_en_i) begin
      if (addr_i == 4'd0) cfg_q <= wdata_i;
      if (addr_i == 4'd1) begin
        mode_q  <= wdata_i[4];
        len_q   <= wdata_i[5];
        msken_q <= wdata_i[6];
        gmask_q <= wdata_i[8 +: SLOTS];
      end
      if (addr_i[3:2] == 2'b01 && 32'(addr_i[1:0]) < SLOTS)
        mask_q[32'(addr_i[1:0])*LINES +: LINES] <= wdata_i[LINES-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i[3:2])
      2'b00: begin
        if (addr_i[1:0] == 2'd0) rdata_o = cfg_q;
        if (addr_i[1:0] == 2'd1) begin
          rdata_o[SLOTS-1:0]  = eff;
          rdata_o[4]          = mode_q;
          rdata_o[5]          = len_q;
          rdata_o[6]          = msken_q;
          rdata_o[8 +: SLOTS] = gmask_q;
        end
        if (addr_i[1:0] == 2'd2) rdata_o = {8'h00, ack};
      end
      2'b01:
        if (32'(addr_i[1:0]) < SLOTS)
          rdata_o[LINES-1:0] = mask_q[32'(addr_i[1:0])*LINES +: LINES];
      2'b10:
        if (32'(addr_i[1:0]) < SLOTS)
          rdata_o[LINES-1:0] = status[32'(addr_i[1:0])*LINES +: LINES];
      default: rdata_o = '0;
    endcase
  end

  p_irq_needs_vector_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && irq_o) |-> (ack != 8'hFF));
  p_legacy_needs_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && irq_o) |-> (req_i != '0));
  p_idle_vector_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff == '0) |-> (ack == 8'hFF));
  p_busy_vector_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff != '0) |-> (ack != 8'hFF));
  p_mask_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_q));
endmodule

// File: tb/slot_irq_aggregator_tb.sv
module slot_irq_aggregator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [63:0] req = '0;
  logic        irq;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  slot_irq_aggregator dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .req_i(req), .irq_o(irq));

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int s = 0; s < 4; s++) begin
      rd(4'(4 + s), v); check("R1 mask reset", v, 16'hFFFF);
    end
    rd(4'd1, v); check("R1 master reset", v, 16'h0000);
    rd(4'd0, v); check("R1 cfg reset", v, 16'h0000);
    rd(4'd2, v); check("R1 ack reset", v, 16'h00FF);
    check("R1 irq reset", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_cfg();
    logic [15:0] v;
    wr(4'd0, 16'hA5C3); rd(4'd0, v); check("R12 cfg readback", v, 16'hA5C3);
  endtask

  task automatic t_masking();
    logic [15:0] v;
    req = '1;
    wr(4'd5, 16'h0F0F);
    rd(4'd9, v); check("R2 status slot1", v, 16'hF0F0);
    rd(4'd8, v); check("R2 masked slot0", v, 16'h0000);
    rd(4'd1, v); check("R3 summary", v & 16'h000F, 16'h0002);
    req = '0;
    rd(4'd9, v); check("R11 status clears on deassert", v, 16'h0000);
    wr(4'd5, 16'hFFFF);
  endtask

  task automatic t_priority();
    logic [15:0] v;
    wr(4'd1, 16'h0010);
    for (int s = 0; s < 4; s++) wr(4'(4 + s), 16'h0000);
    req = '0; req[16 + 3] = 1'b1; req[16 + 9] = 1'b1; req[48 + 0] = 1'b1;
    rd(4'd2, v); check("R4 R5 slot1 over slot3", v, 16'h0024);
    check("R8 irq mode1", {15'd0, irq}, 16'd1);
    rd(4'd2, v); check("R11 ack reread stable", v, 16'h0024);
    req = '0; req[15] = 1'b1; req[16 + 2] = 1'b1;
    rd(4'd2, v); check("R6 line15 carry", v, 16'h0020);
    req = '0; req[48 + 7] = 1'b1; req[48 + 12] = 1'b1;
    rd(4'd2, v); check("R6 slot3 line7", v, 16'h0048);
    req = '0; req[0] = 1'b1; req[63] = 1'b1;
    rd(4'd2, v); check("R6 slot0 line0", v, 16'h0011);
    req = '0;
    rd(4'd2, v); check("R7 none pending", v, 16'h00FF);
    check("R8 irq idle", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_gmask();
    logic [15:0] v;
    req = '0; req[5] = 1'b1; req[32 + 1] = 1'b1;
    wr(4'd1, 16'h0110);
    rd(4'd2, v); check("R10 gmask ignored", v, 16'h0016);
    wr(4'd1, 16'h0150);
    rd(4'd2, v); check("R10 gmask blocks slot0", v, 16'h0032);
    rd(4'd1, v); check("R10 summary blocked", v & 16'h000F, 16'h0004);
    wr(4'd1, 16'h0550);
    check("R10 irq all blocked", {15'd0, irq}, 16'd0);
    req = '0;
  endtask

  task automatic t_legacy();
    req = '0;
    for (int s = 0; s < 4; s++) wr(4'(4 + s), 16'hFFFF);
    wr(4'd1, 16'h0000); req[40] = 1'b1; #1;
    check("R9 legacy disabled", {15'd0, irq}, 16'd0);
    wr(4'd1, 16'h0020); #1;
    check("R9 legacy masked req passes", {15'd0, irq}, 16'd1);
    req = '0; #1;
    check("R9 legacy no req", {15'd0, irq}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_cfg(); t_masking(); t_priority(); t_gmask(); t_legacy();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule